// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of an asynchronous 8-bit parallel flash device and decides when an embedded program or erase operation has finished. It does not drive bus waveforms. It asks a separate bus cycle engine for transfers through a request and acknowledge handshake, and uses each returned status byte only once the engine has acknowledged it.

After a start pulse, the poller reads the status byte at the operation's address twice in a row and compares the toggle flag between the two reads. A stable flag means the device has finished. A moving flag means the device is busy. The poller then looks at the timeout flag of the later read. If that flag is clear, it polls again. If it is set, the toggle flag may have stopped at the same moment as the timeout rose, so the poller takes one more pair of reads before it gives a verdict.

A failed operation ends with a single reset-command write, so that the device goes back to array reads. A bounded number of poll pairs keeps the poller from waiting forever on a device that never settles.

Top module: `toggle_poller`

## Requirements
- R1: After a synchronous reset, `bus_req`, `done` and `fail` are all low.
- R2: A start pulse in idle latches `op_addr` and begins a pair of read transfers to that address with `bus_we` low. A transfer completes on a cycle where `bus_req` and `bus_ack` are both high. `bus_req`, `bus_we` and `bus_addr` hold steady until that cycle, whatever the acknowledge latency.
- R3: If bit 6 of the two reads in a pair is equal, `done` is high for exactly one cycle, two cycles after the acknowledge of the second read. No write follows, and `bus_req` stays low from then on.
- R4: If bit 6 differs and bit 5 of the second read is 0, another pair of reads is issued.
- R5: If bit 6 differs and bit 5 of the second read is 1, one recheck pair is read. If bit 6 is equal across the recheck pair, the result is `done`.
- R6: If bit 6 still differs across the recheck pair, the poller writes 0xF0 to the latched address. `fail` rises in the cycle after that write is acknowledged, and `done` does not pulse.
- R7: After MAX_POLLS pairs in which bit 6 differed and bit 5 of the second read was 0, the poller takes the failure path of R6 instead of issuing another pair.
- R8: `fail` stays high until the next accepted start and is low from the cycle after that start.
- R9: A start pulse while an operation is in progress has no effect on the transfers issued or on the result.
- R10: Bit 5 of the first read in a pair has no effect on the decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling; accepted only when idle |
| op_addr | input | AW | Address of the operation, latched at start |
| bus_req | output | 1 | Transfer request to the bus engine |
| bus_we | output | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | output | AW | Transfer address |
| bus_wdata | output | DW | Write data (reset command) |
| bus_ack | input | 1 | Transfer acknowledge from the bus engine |
| bus_rdata | input | DW | Read data, valid while `bus_ack` is high |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Sticky failure flag |

## Verification
Every result is timed from the acknowledge that triggers it. `done` is due two clock edges after the acknowledge of the deciding read. `fail` is due one edge after the acknowledge of the reset write. A start clears `fail` one edge after it is sampled.

The bench keeps a queue of expected transfers, worked out from the scripted status bytes, and counts edges since the last completed transfer. On every falling edge it compares `done`, `fail` and `bus_req` against the values due at that count. Acknowledge latencies of zero to two cycles are used, so the checks do not rely on a fixed bus delay.

// File: rtl/toggle_poller_pkg.sv
package toggle_poller_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_A,
    ST_RD_B,
    ST_EVAL,
    ST_WR_RST
  } tp_state_e;

  typedef struct packed {
    logic toggled;
    logic timeout_flag;
  } tp_verdict_t;

endpackage

// File: rtl/tp_bus_master.sv
module tp_bus_master #(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter logic [DW-1:0] RESET_CMD = 'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_addr,
  input  logic [AW-1:0] addr_in,
  input  logic          launch_rd,
  input  logic          launch_wr,
  input  logic          bus_ack,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic          xfer_ok
);

  assign xfer_ok = bus_req & bus_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      if (load_addr) begin
        bus_addr <= addr_in;
      end
      if (launch_wr) begin
        bus_req   <= 1'b1;
        bus_we    <= 1'b1;
        bus_wdata <= RESET_CMD;
      end else if (launch_rd) begin
        bus_req   <= 1'b1;
        bus_we    <= 1'b0;
        bus_wdata <= '0;
      end else if (bus_ack) begin
        bus_req <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tp_toggle_eval.sv
module tp_toggle_eval
  import toggle_poller_pkg::*;
#(
  parameter int DW         = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int FAIL_BIT   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cap_a,
  input  logic          cap_b,
  input  logic [DW-1:0] rdata,
  output tp_verdict_t   verdict
);

  logic [DW-1:0] byte_a;
  logic [DW-1:0] byte_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_a <= '0;
      byte_b <= '0;
    end else begin
      if (cap_a) byte_a <= rdata;
      if (cap_b) byte_b <= rdata;
    end
  end

  always_comb begin
    verdict.toggled      = byte_a[TOGGLE_BIT] ^ byte_b[TOGGLE_BIT];
    verdict.timeout_flag = byte_b[FAIL_BIT];
  end

endmodule

// File: rtl/tp_poll_limit.sv
module tp_poll_limit #(
  parameter int MAX_POLLS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);

  localparam int CW = $clog2(MAX_POLLS + 1);
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign hit = (cnt == LAST);

endmodule

// File: rtl/toggle_poller.sv
module toggle_poller
  import toggle_poller_pkg::*;
#(
  parameter int AW         = 19,
  parameter int DW         = 8,
  parameter int MAX_POLLS  = 256,
  parameter int TOGGLE_BIT = 6,
  parameter int FAIL_BIT   = 5,
  parameter logic [DW-1:0] RESET_CMD = 'hF0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] op_addr,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          done,
  output logic          fail
);

  tp_state_e   state, state_nx;
  tp_verdict_t verdict;
  logic        recheck;
  logic        xfer_ok, limit_hit;
  logic        launch_rd, launch_wr, load_addr;
  logic        cap_a, cap_b, cnt_clr, cnt_inc;
  logic        done_set, fail_set, recheck_set;

  tp_bus_master #(.AW(AW), .DW(DW), .RESET_CMD(RESET_CMD)) u_bus (
    .clk(clk), .rst(rst), .load_addr(load_addr), .addr_in(op_addr),
    .launch_rd(launch_rd), .launch_wr(launch_wr), .bus_ack(bus_ack),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .xfer_ok(xfer_ok)
  );

  tp_toggle_eval #(.DW(DW), .TOGGLE_BIT(TOGGLE_BIT), .FAIL_BIT(FAIL_BIT)) u_eval (
    .clk(clk), .rst(rst), .cap_a(cap_a), .cap_b(cap_b),
    .rdata(bus_rdata), .verdict(verdict)
  );

  tp_poll_limit #(.MAX_POLLS(MAX_POLLS)) u_limit (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .hit(limit_hit)
  );

  always_comb begin
    state_nx    = state;
    launch_rd   = 1'b0;
    launch_wr   = 1'b0;
    load_addr   = 1'b0;
    cap_a       = 1'b0;
    cap_b       = 1'b0;
    cnt_clr     = 1'b0;
    cnt_inc     = 1'b0;
    done_set    = 1'b0;
    fail_set    = 1'b0;
    recheck_set = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          load_addr = 1'b1;
          launch_rd = 1'b1;
          cnt_clr   = 1'b1;
          state_nx  = ST_RD_A;
        end
      end
      ST_RD_A: begin
        if (xfer_ok) begin
          cap_a     = 1'b1;
          launch_rd = 1'b1;
          state_nx  = ST_RD_B;
        end
      end
      ST_RD_B: begin
        if (xfer_ok) begin
          cap_b    = 1'b1;
          state_nx = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (!verdict.toggled) begin
          done_set = 1'b1;
          state_nx = ST_IDLE;
        end else if (recheck || (!verdict.timeout_flag && limit_hit)) begin
          launch_wr = 1'b1;
          state_nx  = ST_WR_RST;
        end else if (verdict.timeout_flag) begin
          recheck_set = 1'b1;
          launch_rd   = 1'b1;
          state_nx    = ST_RD_A;
        end else begin
          cnt_inc   = 1'b1;
          launch_rd = 1'b1;
          state_nx  = ST_RD_A;
        end
      end
      ST_WR_RST: begin
        if (xfer_ok) begin
          fail_set = 1'b1;
          state_nx = ST_IDLE;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      recheck <= 1'b0;
      done    <= 1'b0;
      fail    <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= done_set;
      if (state == ST_IDLE && start) begin
        recheck <= 1'b0;
        fail    <= 1'b0;
      end else begin
        if (recheck_set) recheck <= 1'b1;
        if (fail_set)    fail    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tp_poller_checker.sv
module tp_poller_checker #(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter logic [DW-1:0] RESET_CMD = 'hF0
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_ack,
  input logic          done,
  input logic          fail
);

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req); // R2
  AST_XFER_STABLE: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_we)); // R2
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R3
  AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    done |-> !bus_req); // R3
  AST_WRITE_IS_RESET: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we |-> bus_wdata == RESET_CMD); // R6
  AST_DONE_NOT_FAIL: assert property (@(posedge clk) disable iff (rst)
    done |-> !fail); // R6
  AST_FAIL_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(fail) |-> $past(bus_req && bus_we && bus_ack)); // R6
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
    fail && !start |=> fail); // R8

endmodule

bind toggle_poller tp_poller_checker #(.AW(AW), .DW(DW), .RESET_CMD(RESET_CMD)) u_chk (
  .clk(clk), .rst(rst), .start(start), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .done(done), .fail(fail)
);

// File: tb/toggle_poller_tb.sv
module toggle_poller_tb;
  localparam int AW   = 8;
  localparam int DW   = 8;
  localparam int MAXP = 3;
  localparam logic [7:0] CMD = 8'hF0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] op_addr = '0;
  logic          bus_req, bus_we;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_ack = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic          done, fail;

  always #5 clk = ~clk;

  toggle_poller #(.AW(AW), .DW(DW), .MAX_POLLS(MAXP)) u_dut (
    .clk(clk), .rst(rst), .start(start), .op_addr(op_addr),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .done(done), .fail(fail)
  );

  typedef struct {
    bit            we;
    logic [AW-1:0] addr;
  } xfer_t;

  xfer_t      exp_q[$];
  logic [7:0] scr_q[$];
  int  n_chk = 0, n_fail = 0;
  bit  ended = 1'b1, out_fail = 1'b0, fail_exp = 1'b0;
  int  edges_since = 100;
  int  lat = 0, wait_cnt = 0;
  bit  req_p = 0, ack_p = 0, we_p = 0;
  logic [AW-1:0] addr_p = '0;
  logic [7:0]    wd_p = '0;
  int  xfer_cnt = 0, done_cnt = 0, exp_total = 0;
  bit  start_req = 0;
  logic [AW-1:0] start_addr = '0;

  function automatic void check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [7:0] sbyte(int i);
    return (i < scr_q.size()) ? scr_q[i] : 8'h00;
  endfunction

  // Behavioural model of the algorithm: the list of transfers and the outcome.
  function automatic void build(logic [AW-1:0] a);
    int i = 0;
    int polls = 0;
    logic [7:0] x, y;
    exp_q.delete();
    forever begin
      x = sbyte(i); y = sbyte(i + 1); i += 2;
      exp_q.push_back('{0, a}); exp_q.push_back('{0, a});
      if (x[6] == y[6]) begin out_fail = 0; break; end
      if (y[5]) begin
        x = sbyte(i); y = sbyte(i + 1);
        exp_q.push_back('{0, a}); exp_q.push_back('{0, a});
        out_fail = (x[6] != y[6]);
        break;
      end
      polls++;
      if (polls == MAXP) begin out_fail = 1; break; end
    end
    if (out_fail) exp_q.push_back('{1, a});
    exp_total = exp_q.size();
  endfunction

  function automatic bit model_idle();
    return ended && (edges_since >= (out_fail ? 1 : 2));
  endfunction

  task automatic tick();
    xfer_t e;
    @(negedge clk);
    if (req_p && ack_p) begin
      xfer_cnt++;
      if (exp_q.size() == 0) begin
        check(0, "R2", "unexpected transfer", 1, 0);
      end else begin
        e = exp_q.pop_front();
        check(we_p == e.we, "R2", "transfer direction", we_p, e.we);
        check(addr_p == e.addr, "R2", "transfer address", addr_p, e.addr);
        if (e.we) check(wd_p == CMD, "R6", "reset command data", wd_p, CMD);
        if (exp_q.size() == 0) ended = 1;
      end
      edges_since = 0;
    end
    if (edges_since < 1000) edges_since++;
    if (ended && out_fail && edges_since >= 1) fail_exp = 1;
    check(done === (ended && !out_fail && edges_since == 2), "R3", "done pulse", done,
          ended && !out_fail && edges_since == 2);
    check(fail === fail_exp, "R8", "fail flag", fail, fail_exp);
    if (ended && edges_since >= 1) check(bus_req === 1'b0, "R3", "request after end", bus_req, 0);
    if (done) done_cnt++;
    if (start_req) begin
      start = 1; op_addr = start_addr;
      if (model_idle()) begin
        build(start_addr);
        ended = 0; fail_exp = 0; xfer_cnt = 0; done_cnt = 0;
      end
      start_req = 0;
    end else begin
      start = 0;
    end
    if (bus_ack) begin
      bus_ack = 0;
    end else if (bus_req) begin
      if (wait_cnt >= lat) begin
        bus_ack = 1; wait_cnt = 0;
        if (!bus_we) bus_rdata = (scr_q.size() > 0) ? scr_q.pop_front() : 8'h00;
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
    end
    req_p = bus_req; ack_p = bus_ack; we_p = bus_we; addr_p = bus_addr; wd_p = bus_wdata;
  endtask

  task automatic run(string tag, logic [AW-1:0] a, logic [7:0] s[$], int l,
                     bit exp_fail, int poke);
    int guard = 0;
    lat = l; scr_q = s; start_addr = a; start_req = 1;
    tick();
    while (!model_idle() && guard < 2000) begin
      guard++;
      if (guard == poke) begin start_req = 1; start_addr = ~a; end
      tick();
    end
    check(guard < 2000, tag, "watchdog expired", guard, 2000);
    repeat (4) tick();
    check(xfer_cnt == exp_total, tag, "transfer count", xfer_cnt, exp_total);
    check(fail == exp_fail, tag, "final result fail", fail, exp_fail);
    check(done_cnt == (exp_fail ? 0 : 1), tag, "done pulses", done_cnt, exp_fail ? 0 : 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(bus_req === 1'b0, "R1", "reset req", bus_req, 0);
    check(done === 1'b0, "R1", "reset done", done, 0);
    check(fail === 1'b0, "R1", "reset fail", fail, 0);
    rst = 0;
    repeat (2) tick();
    // R3: stable toggle bit on the first pair
    run("R3", 8'h11, '{8'h00, 8'h00}, 0, 0, 0);
    // R4 and R9: two busy pairs, then stable; a start pulse arrives mid-run
    run("R4", 8'h22, '{8'h00, 8'h40, 8'h40, 8'h00, 8'h44, 8'h44}, 1, 0, 4);
    check(xfer_cnt == 6, "R9", "start while busy ignored", xfer_cnt, 6);
    // R5: timeout flag seen, recheck shows toggling stopped
    run("R5", 8'h33, '{8'h00, 8'h60, 8'h20, 8'h20}, 2, 0, 0);
    // R6: timeout flag seen, recheck still toggling
    run("R6", 8'h44, '{8'h00, 8'h60, 8'h40, 8'h00}, 1, 1, 0);
    repeat (10) tick();
    check(fail === 1'b1, "R8", "fail held while idle", fail, 1);
    // R7 and R10: bit 5 only in first reads, so the limit ends the run
    run("R7", 8'h55, '{8'h20, 8'h40, 8'h60, 8'h00, 8'h20, 8'h40}, 0, 1, 0);
    check(xfer_cnt == 7, "R10", "first-read bit 5 ignored", xfer_cnt, 7);
    // R8: next start clears fail
    run("R8", 8'h66, '{8'h80, 8'h80}, 1, 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL WD watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule